// File: doc/BRIEF.md
# Preemptive Priority Switch Arbiter

This block decides which input port of a router crossbar may drive one shared output port. The output here is the wireless transmit channel. Each cycle every input port presents a request bit, an integer priority (a larger value wins) and a tail-flit flag that marks the last flit of its packet. The arbiter answers with a registered one-hot grant. Among the requesting ports, the grant goes to the port with the highest effective priority. A rotating pointer settles ties, so the port after the last winner has first claim.

A grant lasts for the whole packet. It ends when the holder shows its tail flit or drops its request, and arbitration runs again on the next cycle. A challenger whose effective priority is strictly higher than the holder's takes the grant at once. This is preemption. Each port's raw priority is reduced by a penalty that grows by one for every `DECAY_CYC` cycles the port holds the grant. A long holder therefore loses ground, and other ports can overtake it.

Control is a two-state machine. `ST_IDLE` means no port holds the output. `ST_HOLD` means one port holds it. The transitions are:
- **award** (`ST_IDLE` to `ST_HOLD`): a request is present.
- **release** (`ST_HOLD` to `ST_IDLE`): the holder shows its tail flit or drops its request.
- **preempt** (`ST_HOLD` to `ST_HOLD`, new holder): a strictly stronger challenger appears.
- **keep** (`ST_HOLD` to `ST_HOLD`, same holder): none of the above. A penalty tick happens on every `DECAY_CYC`-th keep cycle.

Top module: `ppa_arbiter`

## Requirements
- R1: `grant` has at most one bit set. A grant bit is only set one cycle after the same port's `req` bit was high.
- R2: While `rst_n` is low, `grant` is all zeros.
- R3: With no grant active and at least one request, the port with the highest effective priority among the requesters is granted at the next clock edge. Ports that are not requesting are never considered, whatever their priority. Effective priority is `prio` (4-bit field `i` of the flat `prio` bus is bits `4*i+3:4*i`) minus the port's penalty, with a floor of 0. Under a long random load, every port gets served.
- R4: Among equal effective priorities, the search starts at the port after the last winner and wraps upward (0,1,2,3,0...). After reset the search starts at port 0.
- R5: While the holder keeps requesting without a tail flit, the grant stays with it against challengers of equal or lower effective priority.
- R6: When the holder shows `tail` or drops `req`, `grant` goes all-zero at the next edge. The next winner is granted one edge later.
- R7: A requesting port whose effective priority is strictly higher than the holder's takes the grant at the next edge.
- R8: Every `DECAY_CYC` consecutive held cycles raise the holder's penalty by one, saturating. A port's penalty clears when it releases the grant by tail or request drop. A preempted port keeps its penalty.
- R9: When no port requests, `grant` is all zeros from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORT | Per-port request for the output |
| prio | input | NPORT*PW | Per-port raw priority, field i at bits PW*i+PW-1:PW*i |
| tail | input | NPORT | Per-port tail-flit flag, meaningful for the holder |
| grant | output | NPORT | Registered one-hot grant |

## Verification
The checker watches the following on every cycle:
- the grant stays one-hot and only goes to a port that requested on the previous cycle;
- a held grant never vanishes while its holder keeps requesting without a tail flit;
- a tail flit or a dropped request empties the grant at the next edge;
- an idle arbiter with a pending request awards at the next edge;
- silence on all request lines leaves the grant empty.

Only the directed scenarios can show which port wins:
- the highest effective priority among requesters;
- rotation on ties;
- strict preemption;
- the exact cycle at which accumulated penalty lets a lower raw priority overtake the holder, and the clearing of that penalty on release.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    // Arbiter control states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,   // output free, award on any request
        ST_HOLD = 1'b1    // one port owns the output
    } ppa_state_t;

endpackage

// File: rtl/ppa_decay_cell.sv
// Per-port penalty register and effective-priority subtractor.
module ppa_decay_cell #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] prio_raw,
    input  logic          bump,
    input  logic          clr,
    output logic [PW-1:0] prio_eff
);

    logic [PW-1:0] pen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q <= '0;
        end else if (clr) begin
            pen_q <= '0;
        end else if (bump && (pen_q != {PW{1'b1}})) begin
            pen_q <= pen_q + 1'b1;
        end
    end

    always_comb begin
        if (prio_raw > pen_q) begin
            prio_eff = prio_raw - pen_q;
        end else begin
            prio_eff = '0;
        end
    end

endmodule

// File: rtl/ppa_pick.sv
// Carry-chain winner search in rotated port order. Each stage either
// forwards the running best (port idle or weaker) or replaces it.
module ppa_pick #(
    parameter int NPORT = 4,
    parameter int PW    = 4,
    parameter int IW    = 2
) (
    input  logic [NPORT-1:0]    req,
    input  logic [NPORT*PW-1:0] eff_flat,
    input  logic [IW-1:0]       start,
    output logic                win_vld,
    output logic [IW-1:0]       win_idx,
    output logic [PW-1:0]       win_pri
);

    logic          c_vld [NPORT+1];
    logic [IW-1:0] c_idx [NPORT+1];
    logic [PW-1:0] c_pri [NPORT+1];

    assign c_vld[0] = 1'b0;
    assign c_idx[0] = '0;
    assign c_pri[0] = '0;

    for (genvar k = 0; k < NPORT; k++) begin : g_stage
        logic [IW:0]   raw;
        logic [IW-1:0] idx;
        logic [PW-1:0] pk;
        logic          take;

        assign raw  = {1'b0, start} + (IW+1)'(k);
        assign idx  = (raw >= (IW+1)'(NPORT)) ? IW'(raw - (IW+1)'(NPORT)) : IW'(raw);
        assign pk   = eff_flat[idx*PW +: PW];
        assign take = req[idx] && (!c_vld[k] || (pk > c_pri[k]));

        assign c_vld[k+1] = c_vld[k] | take;
        assign c_idx[k+1] = take ? idx : c_idx[k];
        assign c_pri[k+1] = take ? pk  : c_pri[k];
    end

    assign win_vld = c_vld[NPORT];
    assign win_idx = c_idx[NPORT];
    assign win_pri = c_pri[NPORT];

endmodule

// File: rtl/ppa_arbiter.sv
module ppa_arbiter
    import ppa_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int PW        = 4,
    parameter int DECAY_CYC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    req,
    input  logic [NPORT*PW-1:0] prio,
    input  logic [NPORT-1:0]    tail,
    output logic [NPORT-1:0]    grant
);

    localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int CW = (DECAY_CYC > 1) ? $clog2(DECAY_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DECAY_CYC - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(NPORT - 1);

    ppa_state_t     st_q, st_d;
    logic [IW-1:0]  hold_q, hold_d;
    logic [IW-1:0]  ptr_q, ptr_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [NPORT-1:0] grant_q, grant_d;

    logic [NPORT-1:0]    bump, clr;
    logic [NPORT*PW-1:0] eff_flat;
    logic                win_vld;
    logic [IW-1:0]       win_idx;
    logic [PW-1:0]       win_pri;
    logic [PW-1:0]       hold_pri;
    logic                hold_done;

    // Per-port penalty cells
    for (genvar i = 0; i < NPORT; i++) begin : g_cell
        ppa_decay_cell #(.PW(PW)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .prio_raw (prio[i*PW +: PW]),
            .bump     (bump[i]),
            .clr      (clr[i]),
            .prio_eff (eff_flat[i*PW +: PW])
        );
    end

    ppa_pick #(.NPORT(NPORT), .PW(PW), .IW(IW)) u_pick (
        .req      (req),
        .eff_flat (eff_flat),
        .start    (ptr_q),
        .win_vld  (win_vld),
        .win_idx  (win_idx),
        .win_pri  (win_pri)
    );

    assign hold_pri  = eff_flat[hold_q*PW +: PW];
    assign hold_done = !req[hold_q] || tail[hold_q];

    // Next-state and transition logic
    always_comb begin
        st_d    = st_q;
        hold_d  = hold_q;
        ptr_d   = ptr_q;
        cnt_d   = cnt_q;
        grant_d = grant_q;
        bump    = '0;
        clr     = '0;
        unique case (st_q)
            ST_IDLE: begin
                grant_d = '0;
                if (win_vld) begin                  // award
                    st_d             = ST_HOLD;
                    hold_d           = win_idx;
                    ptr_d            = (win_idx == IDX_LAST) ? '0 : win_idx + 1'b1;
                    cnt_d            = '0;
                    grant_d[win_idx] = 1'b1;
                end
            end
            ST_HOLD: begin
                if (hold_done) begin                // release
                    st_d        = ST_IDLE;
                    grant_d     = '0;
                    cnt_d       = '0;
                    clr[hold_q] = 1'b1;
                end else if (win_vld && (win_pri > hold_pri)) begin  // preempt
                    hold_d           = win_idx;
                    ptr_d            = (win_idx == IDX_LAST) ? '0 : win_idx + 1'b1;
                    cnt_d            = '0;
                    grant_d          = '0;
                    grant_d[win_idx] = 1'b1;
                end else if (cnt_q == CNT_LAST) begin // keep with penalty tick
                    cnt_d        = '0;
                    bump[hold_q] = 1'b1;
                end else begin                      // keep
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d    = ST_IDLE;
                grant_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
            ptr_q  <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
            ptr_q  <= ptr_d;
            cnt_q  <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else begin
            grant_q <= grant_d;
        end
    end

    assign grant = grant_q;

endmodule

// File: rtl/ppa_arbiter_chk.sv
module ppa_arbiter_chk #(
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] req,
    input logic [NPORT-1:0] tail,
    input logic [NPORT-1:0] grant
);

    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_granted_requested_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~$past(req)) == '0);

    assert_award_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req != '0) |=> (grant != '0));

    assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & req & ~tail)) |=> (grant != '0));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & (tail | ~req))) |=> (grant == '0));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (grant == '0));

endmodule

bind ppa_arbiter ppa_arbiter_chk #(.NPORT(NPORT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .tail  (tail),
    .grant (grant)
);

// File: tb/ppa_arbiter_bench.sv
module ppa_arbiter_bench;

    localparam int CLK_P = 10;
    localparam int NP    = 4;
    localparam int PW    = 4;
    localparam int DECAY = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] req = '0;
    logic [NP*PW-1:0] prio = '0;
    logic [NP-1:0] tail = '0;
    logic [NP-1:0] grant;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ppa_arbiter #(.NPORT(NP), .PW(PW), .DECAY_CYC(DECAY)) u_ppa_arbiter (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .prio  (prio),
        .tail  (tail),
        .grant (grant)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_p(input int port, input int val);
        prio[port*PW +: PW] = PW'(val);
    endtask

    task automatic expect_grant(input logic [NP-1:0] exp, input string tag);
        total++;
        if (grant !== exp) begin
            bad++;
            $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req   = '0;
        tail  = '0;
        prio  = '0;
        step();
        step();
        expect_grant(4'b0000, "R2 grant low in reset");
        rst_n = 1'b1;
    endtask

    // R3, R6, R9: highest requester wins, release bubble, idle silence
    task automatic t_pick();
        do_reset();
        set_p(0, 1); set_p(1, 3); set_p(2, 5); set_p(3, 0);
        req = 4'b1011;
        step();
        expect_grant(4'b0010, "R3 highest requester, idle port2 ignored");
        tail = 4'b0010; req = 4'b1001;
        step();
        expect_grant(4'b0000, "R6 release empties grant");
        tail = '0;
        step();
        expect_grant(4'b0001, "R6 re-arbitration picks port0");
        req = '0;
        step();
        expect_grant(4'b0000, "R9 no request");
        step();
        expect_grant(4'b0000, "R9 stays empty");
    endtask

    // R4: rotating tie break
    task automatic t_tie();
        do_reset();
        set_p(0, 2); set_p(1, 2); set_p(2, 2); set_p(3, 2);
        req = 4'b0110;
        step();
        expect_grant(4'b0010, "R4 tie from port0 picks port1");
        tail = 4'b0010;
        step();
        expect_grant(4'b0000, "R6 tail release");
        tail = '0;
        step();
        expect_grant(4'b0100, "R4 tie after port1 picks port2");
        tail = 4'b0100;
        step();
        tail = '0;
        step();
        expect_grant(4'b0010, "R4 tie wraps to port1");
    endtask

    // R5: hold against equal or lower challengers
    task automatic t_hold();
        do_reset();
        set_p(0, 1); set_p(2, 1); set_p(3, 0);
        req = 4'b0001;
        step();
        expect_grant(4'b0001, "R3 single requester");
        req = 4'b1101;
        for (int k = 0; k < 5; k++) begin
            step();
            expect_grant(4'b0001, "R5 holder kept");
        end
    endtask

    // R7: strict preemption
    task automatic t_preempt();
        do_reset();
        set_p(0, 2); set_p(1, 5); set_p(2, 5); set_p(3, 7);
        req = 4'b0001;
        step();
        expect_grant(4'b0001, "R3 port0 alone");
        req = 4'b0011;
        step();
        expect_grant(4'b0010, "R7 stronger port1 preempts");
        req = 4'b0111;
        step();
        expect_grant(4'b0010, "R7 equal port2 does not preempt");
        req = 4'b1111;
        step();
        expect_grant(4'b1000, "R7 port3 preempts");
    endtask

    // R8: penalty growth, overtaking and clearing on release
    task automatic t_decay();
        do_reset();
        set_p(0, 3); set_p(1, 2);
        req = 4'b0011;
        step();
        expect_grant(4'b0001, "R3 port0 wins on raw priority");
        for (int k = 1; k <= 2*DECAY; k++) begin
            step();
            expect_grant(4'b0001, "R8 holder before penalty overtakes");
        end
        step();
        expect_grant(4'b0010, "R8 decayed holder overtaken");
        req = 4'b0001;
        step();
        expect_grant(4'b0000, "R6 port1 drop releases");
        step();
        expect_grant(4'b0001, "R3 port0 regranted");
        tail = 4'b0001;
        step();
        tail = '0; req = '0;
        step();
        req = 4'b0011;
        step();
        expect_grant(4'b0001, "R8 penalty cleared on release");
    endtask

    // R1, R3: long random load
    task automatic t_random();
        bit [NP-1:0] served = '0;
        bit [NP-1:0] prev;
        do_reset();
        for (int n = 0; n < 20000; n++) begin
            for (int p = 0; p < NP; p++) begin
                req[p]  = ($urandom % 10) < 7;
                tail[p] = ($urandom % 10) < 2;
                set_p(p, int'($urandom % 16));
            end
            prev = req;
            step();
            total++;
            if (!$onehot0(grant) || ((grant & ~prev) != '0)) begin
                bad++;
                $display("FAIL R1 grant=%b expected onehot subset of %b", grant, prev);
            end
            served |= grant;
        end
        req = '0; tail = '0;
        total++;
        if (served != '1) begin
            bad++;
            $display("FAIL R3 served=%b expected=%b", served, 4'b1111);
        end
    endtask

    initial begin
        t_pick();
        t_tie();
        t_hold();
        t_preempt();
        t_decay();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule